// File: doc/BRIEF.md
# Sub-Word Register Access Adapter

This block sits between a simple memory-mapped request port and a bank of 64-bit registers. Each request may be 1, 2, 4 or 8 bytes wide and must be naturally aligned. The low address bits give the byte lane inside the 64-bit word, and the upper bits give the register number. On a legal write the adapter reads the current register value through a combinational read port. In the same cycle it merges the new bytes into that value and drives a write strobe with the register number, a per-bit enable mask and the merged word. On a legal read it moves the addressed bytes down to bit 0, clears all other bits, and returns the result one cycle after the request.

Some requests are refused: an illegal size, an offset that is not a multiple of the size, or a register number at or above the number of implemented registers. A refused request never writes the bank. It pulses a fault flag one cycle later. A refused read still returns a response, and its data is zero.

The response side is a four-state machine. State IDLE means no response is due. State RD_OK means a read response carries data. State RD_BAD means a read response carries zero and a fault. State WR_BAD means a refused write reports a fault. The next state depends only on the request of the current cycle:
- no request, or a legal write, goes to IDLE;
- a legal read goes to RD_OK;
- a refused read goes to RD_BAD;
- a refused write goes to WR_BAD.

This transition is the same from every state, so a new request can be accepted on every cycle.

Top module: `sw_access_adapter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `rd_valid` and `fault_o` are 0 and `rd_data` is zero. With no request, `bank_we` is 0.
- R2: `bank_idx` equals `req_addr` shifted right by 3. Address bits [2:0] are the byte offset inside the 64-bit register. Byte n occupies data bits [8n+7:8n] (little-endian).
- R3: `req_size` holds the access width in bytes. Only the values 1, 2, 4 and 8 are legal. Any other value produces no write and a fault, and a read of that size returns zero.
- R4: On a legal write, `bank_be` is all ones over bytes offset through offset+size-1 and zero elsewhere.
- R5: On a legal write, `bank_wdata` equals (old AND NOT `bank_be`) OR ((`req_wdata` AND size mask) << 8*offset). Bits of `req_wdata` above the access size have no effect.
- R6: A legal read returns (register >> 8*offset) AND size mask on `rd_data`, zero-extended, with `rd_valid` high on the cycle after the request.
- R7: An access whose offset is not a multiple of its size faults, does not write, and a read returns zero.
- R8: An access to a register number at or above NUM_REGS faults, does not write, and a read returns zero.
- R9: The write strobe is driven in the same cycle as the write request. A write never produces `rd_valid`.
- R10: `fault_o` pulses for exactly one cycle, on the cycle after each refused request, and never after a legal one.
- R11: Requests on consecutive cycles are each accepted and answered, with no idle cycle needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read data, zero-extended |
| fault_o | output | 1 | Refused-request pulse |
| bank_idx | output | ADDR_W-3 | Register number to the bank |
| bank_we | output | 1 | Write strobe to the bank |
| bank_be | output | 64 | Bit-level enable mask |
| bank_wdata | output | 64 | Merged word to store |
| bank_rdata | input | 64 | Current value of register `bank_idx` |

## Verification
Two internal faults are likely. A wrong lane mask or shift amount appears in the same cycle on `bank_be` or `bank_wdata`. It also appears in the bank contents, so the next read of that register shows wrong bytes. A wrong response state appears one cycle after the request: `rd_valid` or `fault_o` is missing or extra, or a refused read carries nonzero data. Random back-to-back traffic against a bench-side shadow of every register catches a merge fault at the first later read that overlaps the damaged bytes.

// File: rtl/sw_adapt_pkg.sv
package sw_adapt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RD_OK  = 2'd1,
        ST_RD_BAD = 2'd2,
        ST_WR_BAD = 2'd3
    } rsp_state_e;

    typedef struct packed {
        logic size_ok;
        logic aligned;
        logic decoded;
    } access_chk_t;

endpackage

// File: rtl/sw_access_decode.sv
module sw_access_decode
    import sw_adapt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BYTES    = 8,
    parameter int NUM_REGS = 16,
    parameter int OFF_W    = $clog2(BYTES),
    parameter int SIZE_W   = OFF_W + 1,
    parameter int IDX_W    = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  off,
    output access_chk_t       chk,
    output logic [BYTES-1:0]  byte_en
);

    logic [SIZE_W-1:0] size_m1;

    assign idx     = addr[ADDR_W-1:OFF_W];
    assign off     = addr[OFF_W-1:0];
    assign size_m1 = size - SIZE_W'(1);

    always_comb begin
        // one bit set, and no wider than the word
        chk.size_ok = (size != '0) && ((size & size_m1) == '0)
                      && (int'(size) <= BYTES);
        chk.aligned = (({1'b0, off} & size_m1) == '0);
        chk.decoded = (int'(idx) < NUM_REGS);
    end

    always_comb begin
        for (int b = 0; b < BYTES; b++) begin
            byte_en[b] = chk.size_ok && (b >= int'(off))
                         && (b < int'(off) + int'(size));
        end
    end

endmodule

// File: rtl/sw_lane_path.sv
module sw_lane_path #(
    parameter int DATA_W = 64,
    parameter int BYTES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(BYTES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic [BYTES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_word,
    output logic [DATA_W-1:0] bit_en,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] rd_aligned
);

    logic [OFF_W+2:0] shamt;

    assign shamt = {off, 3'b000};

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign bit_en[g*8 +: 8] = {8{byte_en[g]}};
    end

    // bit_en already equals the size mask moved up to the offset
    assign merged     = (old_word & ~bit_en) | ((wdata << shamt) & bit_en);
    assign rd_aligned = (old_word & bit_en) >> shamt;

endmodule

// File: rtl/sw_access_adapter.sv
module sw_access_adapter
    import sw_adapt_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 64,
    localparam int BYTES   = DATA_W / 8,
    localparam int OFF_W   = $clog2(BYTES),
    localparam int SIZE_W  = OFF_W + 1,
    localparam int IDX_W   = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              fault_o,
    output logic [IDX_W-1:0]  bank_idx,
    output logic              bank_we,
    output logic [DATA_W-1:0] bank_be,
    output logic [DATA_W-1:0] bank_wdata,
    input  logic [DATA_W-1:0] bank_rdata
);

    access_chk_t       chk;
    logic [OFF_W-1:0]  off;
    logic [BYTES-1:0]  byte_en;
    logic [DATA_W-1:0] rd_aligned;
    logic [DATA_W-1:0] rd_q;
    logic              legal;
    rsp_state_e        state_q, state_d;

    sw_access_decode #(
        .ADDR_W   (ADDR_W),
        .BYTES    (BYTES),
        .NUM_REGS (NUM_REGS),
        .OFF_W    (OFF_W),
        .SIZE_W   (SIZE_W),
        .IDX_W    (IDX_W)
    ) decode_i (
        .addr    (req_addr),
        .size    (req_size),
        .idx     (bank_idx),
        .off     (off),
        .chk     (chk),
        .byte_en (byte_en)
    );

    sw_lane_path #(
        .DATA_W (DATA_W),
        .BYTES  (BYTES),
        .OFF_W  (OFF_W)
    ) lanes_i (
        .off        (off),
        .byte_en    (byte_en),
        .wdata      (req_wdata),
        .old_word   (bank_rdata),
        .bit_en     (bank_be),
        .merged     (bank_wdata),
        .rd_aligned (rd_aligned)
    );

    assign legal   = chk.size_ok & chk.aligned & chk.decoded;
    assign bank_we = req_valid & req_write & legal;

    // next response, chosen by this cycle's request alone
    always_comb begin
        if (!req_valid)     state_d = ST_IDLE;
        else if (legal)     state_d = req_write ? ST_IDLE   : ST_RD_OK;
        else                state_d = req_write ? ST_WR_BAD : ST_RD_BAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid && !req_write && legal) rd_q <= rd_aligned;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        fault_o  = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_OK: begin
                rd_valid = 1'b1;
                rd_data  = rd_q;
            end
            ST_RD_BAD: begin
                rd_valid = 1'b1;
                fault_o  = 1'b1;
            end
            ST_WR_BAD: fault_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sw_access_adapter_chk.sv
module sw_access_adapter_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              fault_o,
    input logic              bank_we,
    input logic [DATA_W-1:0] bank_be,
    input logic [DATA_W-1:0] bank_wdata,
    input logic [DATA_W-1:0] bank_rdata
);

    // R9
    wr_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (req_valid && req_write));

    // R9
    wr_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (!rd_valid && !fault_o));

    // R4
    be_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> ($countones(bank_be) == 8 || $countones(bank_be) == 16 ||
                     $countones(bank_be) == 32 || $countones(bank_be) == 64));

    // R5
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |-> (((bank_wdata ^ bank_rdata) & ~bank_be) == '0));

    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && fault_o) |-> (rd_data == '0));

    // R6
    rd_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R10
    fault_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $past(req_valid));

endmodule

bind sw_access_adapter sw_access_adapter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .fault_o    (fault_o),
    .bank_we    (bank_we),
    .bank_be    (bank_be),
    .bank_wdata (bank_wdata),
    .bank_rdata (bank_rdata)
);

// File: tb/sw_access_adapter_tb.sv
module sw_access_adapter_tb_top;

    localparam int ADDR_W   = 12;
    localparam int NUM_REGS = 16;
    localparam int IDX_W    = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [3:0]        req_size = 4'd0;
    logic [63:0]       req_wdata = '0;
    logic              rd_valid;
    logic [63:0]       rd_data;
    logic              fault_o;
    logic [IDX_W-1:0]  bank_idx;
    logic              bank_we;
    logic [63:0]       bank_be;
    logic [63:0]       bank_wdata;
    logic [63:0]       bank_rdata;

    logic [63:0] mem    [NUM_REGS];
    logic [63:0] shadow [NUM_REGS];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sw_access_adapter #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .fault_o(fault_o),
        .bank_idx(bank_idx), .bank_we(bank_we), .bank_be(bank_be),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // register bank model
    assign bank_rdata = (int'(bank_idx) < NUM_REGS) ? mem[bank_idx[3:0]] : 64'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= 64'd0;
        end else if (bank_we) begin
            mem[bank_idx[3:0]] <= bank_wdata;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit exp_legal(input logic [ADDR_W-1:0] a, input logic [3:0] sz);
        bit sz_ok = (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
        if (!sz_ok) return 1'b0;
        if ((int'(a) % int'(sz)) != 0) return 1'b0;
        return (int'(a) / 8) < NUM_REGS;
    endfunction

    function automatic logic [63:0] low_mask(input logic [3:0] sz);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) if (i < 8 * int'(sz)) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] exp_be(input int off, input logic [3:0] sz);
        logic [63:0] m = '0;
        for (int b = 0; b < 8; b++)
            if (b >= off && b < off + int'(sz)) m[b*8 +: 8] = 8'hFF;
        return m;
    endfunction

    // drive at a falling edge, check the strobe, then check the response
    task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [3:0] sz, input logic [63:0] wd);
        bit          ok  = exp_legal(a, sz);
        int          idx = int'(a) / 8;
        int          off = int'(a) % 8;
        logic [63:0] old = (idx < NUM_REGS) ? shadow[idx] : 64'd0;
        logic [63:0] be  = exp_be(off, sz);
        logic [63:0] nw;
        logic [63:0] rv;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        #1;
        check("R9 write strobe", 64'(bank_we), 64'(wr && ok));
        check("R2 register index", 64'(bank_idx), 64'(idx));
        if (wr && ok) begin
            nw = (old & ~be) | ((wd & low_mask(sz)) << (8 * off));
            check("R4 byte-enable mask", bank_be, be);
            check("R5 merged word", bank_wdata, nw);
            shadow[idx] = nw;
        end
        rv = ok ? ((old >> (8 * off)) & low_mask(sz)) : 64'd0;
        @(negedge clk);
        check("R10 fault pulse", 64'(fault_o), 64'(!ok));
        check("R6 read valid", 64'(rd_valid), 64'(!wr));
        if (!wr) check(ok ? "R6 read data" : "R8 refused read data", rd_data, rv);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] sz;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NUM_REGS; i++) shadow[i] = 64'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        check("R1 fault in reset", 64'(fault_o), 64'd0);
        check("R1 rd_data in reset", rd_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        check("R1 bank_we idle", 64'(bank_we), 64'd0);

        // full word, then sub-word writes with junk above the size (R5)
        access(1'b1, 12'h008, 4'd8, 64'h0123_4567_89AB_CDEF);
        access(1'b1, 12'h00B, 4'd1, 64'hFFFF_FFFF_FFFF_FF5A);
        access(1'b1, 12'h00E, 4'd2, 64'hDEAD_BEEF_0000_C3D2);
        access(1'b1, 12'h00C, 4'd4, 64'h1111_1111_7766_5544);
        idle();
        // R6 readback at every width
        access(1'b0, 12'h008, 4'd8, 64'd0);
        access(1'b0, 12'h00E, 4'd2, 64'd0);
        access(1'b0, 12'h00B, 4'd1, 64'd0);
        access(1'b0, 12'h00C, 4'd4, 64'd0);
        idle();
        // R3 illegal sizes: nothing written, read gives zero
        access(1'b1, 12'h008, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b1, 12'h008, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        access(1'b0, 12'h008, 4'd15, 64'd0);
        access(1'b0, 12'h008, 4'd8, 64'd0);
        // R7 misaligned
        access(1'b1, 12'h009, 4'd2, 64'hFFFF);
        access(1'b1, 12'h00A, 4'd4, 64'hFFFF_FFFF);
        access(1'b0, 12'h00C, 4'd8, 64'd0);
        access(1'b0, 12'h008, 4'd8, 64'd0);
        // R8 undecoded registers
        access(1'b1, 12'(NUM_REGS * 8), 4'd8, 64'hA5A5_A5A5_A5A5_A5A5);
        access(1'b0, 12'(NUM_REGS * 8), 4'd8, 64'd0);
        access(1'b0, 12'hFF8, 4'd1, 64'd0);
        idle();
        check("R10 fault single pulse", 64'(fault_o), 64'd0);

        // R11 back-to-back random traffic
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) < 8) sz = 4'(1 << $urandom_range(0, 3));
            else sz = 4'($urandom_range(0, 15));
            access(1'($urandom_range(0, 1)),
                   12'($urandom_range(0, NUM_REGS * 8 + 15)),
                   sz, {$urandom, $urandom});
        end
        idle();
        // R6 final sweep of every register
        for (int i = 0; i < NUM_REGS; i++) access(1'b0, 12'(i * 8), 4'd8, 64'd0);
        idle();
        check("R11 quiet after traffic", 64'({rd_valid, fault_o}), 64'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule